// File: doc/BRIEF.md
# Cartridge PRG bank controller (CPU side)

This block is the processor-facing half of a bank-switching cartridge controller for an 8-bit console. It watches CPU writes in the upper half of the address space and captures two program-bank numbers and a mirroring bit. It then maps every CPU read address in the ROM space onto a program ROM address. The ROM space holds two switchable 8 KiB windows, and the top 16 KiB always maps to the last two banks of the ROM.

The block also holds a single-bit scratch latch in the $6000-$6FFF page. Reads there return the latch in bit 0 and the last value seen on the data bus in the other bits. Every other read leaves the bus at its last value. The mirroring bit decides whether the nametable select follows picture-address line 10 or line 11. A parameter picks the board wiring, which may swap CPU address lines A0 and A1 at the decoder. A second parameter gives the ROM size as a power-of-two count of 8 KiB banks.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After reset, both switchable bank registers, the mirroring bit and the latch are zero. Reads at $8000 and $A000 then map to bank 0, the nametable select follows ppu_a10, and the latch reads back as 0.
- R2: A write whose address has A15-A12 = 4'h8 loads cpu_wdata[4:0] into the first bank register on that clock edge. Data bits 7-5 are dropped, and the register holds its value between such writes.
- R3: A write whose address has A15-A12 = 4'hA loads cpu_wdata[4:0] into the second bank register.
- R4: For CPU addresses $8000-$9FFF, prg_addr = {first bank, A12-A0}. For $A000-$BFFF, prg_addr = {second bank, A12-A0}. prg_addr is combinational from the current address.
- R5: For $C000-$DFFF, prg_addr = {PRG_BANKS-2, A12-A0}. For $E000-$FFFF, prg_addr = {PRG_BANKS-1, A12-A0}.
- R6: The bank number used in R4 is the register value masked to PRG_BANKS-1, where PRG_BANKS is a power of two between 4 and 32.
- R7: A write with A15-A12 = 4'h9 loads only data bit 0 into the mirroring bit, so a write of $FF changes no other state. ciram_a10 equals ppu_a11 when the bit is 1 and ppu_a10 when it is 0.
- R8: A write with A15-A12 = 4'h6 loads data bit 0 into the latch. A read with A15-A12 = 4'h6 raises rd_drive and returns {bus_last[7:1], latch}.
- R9: Every read outside $6000-$6FFF, including $7000-$7FFF, leaves rd_drive low and gives rd_data = bus_last.
- R10: Writes to pages $0-$5, $7 and $B-$F change no bank register, mirroring bit or latch.
- R11: Every register accepts all four sub-addresses (A1,A0). This holds in both wiring variants (SWAP_A01 = 0 or 1), so writes at $x001 and $x002 reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per CPU write |
| cpu_rd | input | 1 | Read qualifier |
| bus_last | input | 8 | Last value seen on the CPU data bus (open-bus value) |
| ppu_a10 | input | 1 | Picture-side address line 10 |
| ppu_a11 | input | 1 | Picture-side address line 11 |
| rd_data | output | 8 | Read data presented to the CPU |
| rd_drive | output | 1 | High when the block drives the data bus |
| prg_addr | output | BANK_W+13 | Program ROM address |
| ciram_a10 | output | 1 | Nametable select |

## Verification
The bench writes $FF to the mirroring page and checks that only the mirroring bit changed. A design that stored more data bits would corrupt the bank mapping or the latch. It also writes data with bits 7-5 set to the bank pages; a register too wide would point past the ROM. A second instance with a swapped A0/A1 wiring and a 16-bank ROM receives the same writes, including values above 15. A missing mask or a decoder that skips a sub-address would show up as a wrong prg_addr on that instance. Reads in the $7000 page and in the latch page are checked against the open-bus value, which catches a latch that leaks into the wrong page or upper bits that are not taken from the bus.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  localparam int PRG_REG_W = 5;

  localparam logic [3:0] PAGE_LATCH = 4'h6;
  localparam logic [3:0] PAGE_PRG0  = 4'h8;
  localparam logic [3:0] PAGE_MIRR  = 4'h9;
  localparam logic [3:0] PAGE_PRG1  = 4'hA;

  typedef struct packed {
    logic [PRG_REG_W-1:0] prg0;
    logic [PRG_REG_W-1:0] prg1;
    logic                 mirr;
    logic                 latch;
  } mpr_state_t;

endpackage

// File: rtl/mpr_wr_decode.sv
module mpr_wr_decode #(
  parameter bit SWAP_A01 = 1'b0
) (
  input  logic [3:0] page,
  input  logic [1:0] a_lo,
  input  logic       wr_en,
  output logic       we_prg0,
  output logic       we_prg1,
  output logic       we_mirr,
  output logic       we_latch
);
  import mpr_pkg::*;

  logic [1:0] sub;

  // board wiring variant: normalise the sub-address lines
  generate
    if (SWAP_A01) begin : g_swap
      assign sub = {a_lo[0], a_lo[1]};
    end else begin : g_norm
      assign sub = a_lo;
    end
  endgenerate

  logic [3:0] hit_prg0;
  logic [3:0] hit_prg1;
  logic [3:0] hit_mirr;

  // one strobe per sub-address slot; every slot of a page aliases the same register
  for (genvar s = 0; s < 4; s++) begin : g_sub
    assign hit_prg0[s] = wr_en && (page == PAGE_PRG0) && (sub == 2'(s));
    assign hit_prg1[s] = wr_en && (page == PAGE_PRG1) && (sub == 2'(s));
    assign hit_mirr[s] = wr_en && (page == PAGE_MIRR) && (sub == 2'(s));
  end

  always_comb begin
    we_prg0  = |hit_prg0;
    we_prg1  = |hit_prg1;
    we_mirr  = |hit_mirr;
    we_latch = wr_en && (page == PAGE_LATCH);
  end

endmodule

// File: rtl/mpr_regs.sv
module mpr_regs (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_prg0,
  input  logic                we_prg1,
  input  logic                we_mirr,
  input  logic                we_latch,
  input  logic [7:0]          wdata,
  output mpr_pkg::mpr_state_t st
);
  import mpr_pkg::*;

  mpr_state_t st_q;
  mpr_state_t st_d;

  always_comb begin
    st_d = st_q;
    if (we_prg0)  st_d.prg0  = wdata[PRG_REG_W-1:0];
    if (we_prg1)  st_d.prg1  = wdata[PRG_REG_W-1:0];
    if (we_mirr)  st_d.mirr  = wdata[0];
    if (we_latch) st_d.latch = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (we_prg0 || we_prg1 || we_mirr || we_latch) begin
      st_q <= st_d;
    end
  end

  assign st = st_q;

  AST_PRG0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_prg0 |=> st_q.prg0 == $past(wdata[PRG_REG_W-1:0])); // R2
  AST_PRG0_HIGH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_prg0 && (|wdata[7:5])) |=> st_q.prg0 == $past(wdata[4:0])); // R2
  AST_PRG1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_prg1 |=> st_q.prg1 == $past(wdata[PRG_REG_W-1:0])); // R3
  AST_MIRR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_mirr |=> (st_q.mirr == $past(wdata[0])) && $stable(st_q.prg0) && $stable(st_q.prg1)); // R7
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_latch |=> st_q.latch == $past(wdata[0])); // R8
  AST_PRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_prg0 || we_prg1) |=> $stable(st_q.prg0) && $stable(st_q.prg1)); // R10

endmodule

// File: rtl/mpr_xlate.sv
module mpr_xlate #(
  parameter int PRG_BANKS = 32,
  localparam int BANK_W = $clog2(PRG_BANKS),
  localparam int ROM_AW = BANK_W + 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [14:0]         addr,
  input  mpr_pkg::mpr_state_t st,
  output logic [ROM_AW-1:0]   prg_addr
);
  import mpr_pkg::*;

  localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(PRG_BANKS - 1);
  localparam logic [BANK_W-1:0] BANK_PREV = BANK_W'(PRG_BANKS - 2);

  logic [BANK_W-1:0] bank;

  // power-of-two size: truncation is the mask
  always_comb begin
    unique case (addr[14:13])
      2'b00:   bank = BANK_W'(st.prg0);
      2'b01:   bank = BANK_W'(st.prg1);
      2'b10:   bank = BANK_PREV;
      default: bank = BANK_LAST;
    endcase
    prg_addr = {bank, addr[12:0]};
  end

  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    addr[14] |-> (&prg_addr[ROM_AW-1:14])); // R5
  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    addr[14] |-> (prg_addr[13] == addr[13])); // R5

endmodule

// File: rtl/mpr_rdata.sv
module mpr_rdata (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] page,
  input  logic       cpu_rd,
  input  logic [7:0] bus_last,
  input  logic       latch,
  output logic [7:0] rd_data,
  output logic       rd_drive
);
  import mpr_pkg::*;

  always_comb begin
    rd_drive = cpu_rd && (page == PAGE_LATCH);
    rd_data  = bus_last;
    if (rd_drive) rd_data[0] = latch;
  end

  AST_OPEN_BUS_7PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (page == 4'h7) |-> (!rd_drive && rd_data == bus_last)); // R9
  AST_UPPER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> rd_data[7:1] == bus_last[7:1]); // R8

endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl #(
  parameter bit SWAP_A01 = 1'b0,
  parameter int PRG_BANKS = 32,
  localparam int BANK_W = $clog2(PRG_BANKS),
  localparam int ROM_AW = BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        bus_last,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [7:0]        rd_data,
  output logic              rd_drive,
  output logic [ROM_AW-1:0] prg_addr,
  output logic              ciram_a10
);
  import mpr_pkg::*;

  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       we_prg0;
  logic       we_prg1;
  logic       we_mirr;
  logic       we_latch;
  mpr_state_t st;

  mpr_wr_decode #(.SWAP_A01(SWAP_A01)) u_dec (
    .page     (cpu_addr[15:12]),
    .a_lo     (cpu_addr[1:0]),
    .wr_en    (cpu_wr),
    .we_prg0  (we_prg0),
    .we_prg1  (we_prg1),
    .we_mirr  (we_mirr),
    .we_latch (we_latch)
  );

  mpr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .we_prg0  (we_prg0),
    .we_prg1  (we_prg1),
    .we_mirr  (we_mirr),
    .we_latch (we_latch),
    .wdata    (cpu_wdata),
    .st       (st)
  );

  mpr_xlate #(.PRG_BANKS(PRG_BANKS)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .addr     (cpu_addr[14:0]),
    .st       (st),
    .prg_addr (prg_addr)
  );

  mpr_rdata u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .page     (cpu_addr[15:12]),
    .cpu_rd   (cpu_rd),
    .bus_last (bus_last),
    .latch    (st.latch),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
  );

  assign ciram_a10 = st.mirr ? ppu_a11 : ppu_a10;

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({we_prg0, we_prg1, we_mirr, we_latch})); // R10
  AST_WE_NONE_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cpu_addr[15:12] == 4'h7 || cpu_addr[15:12] >= 4'hB) |->
      !(we_prg0 || we_prg1 || we_mirr || we_latch)); // R10
  AST_MIRR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ppu_a10 == ppu_a11) |-> ciram_a10 == ppu_a10); // R7

endmodule

// File: tb/sim_prg_bank_ctrl.sv
module sim_prg_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  bus_last = '0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;

  logic [7:0]  rd_data0, rd_data1;
  logic        rd_drive0, rd_drive1;
  logic [17:0] prg_addr0;
  logic [16:0] prg_addr1;
  logic        ciram0, ciram1;

  int checks = 0;
  int errors = 0;

  // model state
  int m_p0 = 0, m_p1 = 0, m_mir = 0, m_lat = 0;

  always #10 clk = ~clk;

  prg_bank_ctrl #(.SWAP_A01(1'b0), .PRG_BANKS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .bus_last(bus_last),
    .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .rd_data(rd_data0),
    .rd_drive(rd_drive0), .prg_addr(prg_addr0), .ciram_a10(ciram0));

  prg_bank_ctrl #(.SWAP_A01(1'b1), .PRG_BANKS(16)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .bus_last(bus_last),
    .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .rd_data(rd_data1),
    .rd_drive(rd_drive1), .prg_addr(prg_addr1), .ciram_a10(ciram1));

  function automatic int exp_prg(int a, int p0, int p1, int nb);
    int b;
    case ((a >> 13) & 3)
      0: b = p0 & (nb - 1);
      1: b = p1 & (nb - 1);
      2: b = nb - 2;
      default: b = nb - 1;
    endcase
    return b * 8192 + (a & 8191);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(int a, int d);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
    case ((a >> 12) & 15)
      8:  m_p0  = d & 31;
      10: m_p1  = d & 31;
      9:  m_mir = d & 1;
      6:  m_lat = d & 1;
      default: ;
    endcase
  endtask

  task automatic read_rom(string req, int a);
    cpu_addr = 16'(a); cpu_rd = 1'b1;
    #2;
    check({req, " u0 prg_addr"}, int'(prg_addr0), exp_prg(a, m_p0, m_p1, 32));
    check({req, " R6 u1 prg_addr"}, int'(prg_addr1), exp_prg(a, m_p0, m_p1, 16));
  endtask

  task automatic read_all(string req);
    int a;
    int bl;
    a = 32'h8000 | int'($urandom_range(0, 32767));
    read_rom(((a >> 14) & 1) == 1 ? {req, " R5"} : {req, " R4"}, a);
    ppu_a10 = 1'($urandom); ppu_a11 = 1'($urandom);
    #1;
    check({req, " R7 ciram"}, int'(ciram0), m_mir ? int'(ppu_a11) : int'(ppu_a10));
    check({req, " R7 ciram u1"}, int'(ciram1), m_mir ? int'(ppu_a11) : int'(ppu_a10));
    bl = int'($urandom_range(0, 255));
    bus_last = 8'(bl);
    cpu_addr = 16'(32'h6000 | int'($urandom_range(0, 4095)));
    #1;
    check({req, " R8 latch read"}, int'(rd_data0), (bl & 254) | m_lat);
    check({req, " R8 drive"}, int'(rd_drive0), 1);
    cpu_addr = 16'(32'h7000 | int'($urandom_range(0, 4095)));
    #1;
    check({req, " R9 open bus"}, int'(rd_data0), bl);
    check({req, " R9 no drive"}, int'(rd_drive0), 0);
    cpu_rd = 1'b0;
  endtask

  function automatic int pick_addr();
    int lo;
    lo = int'($urandom_range(0, 4095));
    case ($urandom_range(0, 7))
      0: return 32'h8000 | lo;
      1: return 32'h9000 | lo;
      2: return 32'hA000 | lo;
      3: return 32'h6000 | lo;
      4: return 32'h7000 | lo;
      5: return 32'hB000 | lo;
      6: return (int'($urandom_range(12, 15)) << 12) | lo;
      default: return (int'($urandom_range(0, 5)) << 12) | lo;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_rom("R1 reset $8000", 32'h8000);
    read_rom("R1 reset $A000", 32'hA123);
    ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
    check("R1 mirror reset", int'(ciram0), 1);
    cpu_addr = 16'h6000; bus_last = 8'hFF; #1;
    check("R1 latch reset", int'(rd_data0), 8'hFE);
    cpu_rd = 1'b0;

    // R2 high data bits dropped
    do_write(32'h8003, 32'hE7);
    read_rom("R2 prg0 load", 32'h8456);
    // R3
    do_write(32'hA000, 32'h0B);
    read_rom("R3 prg1 load", 32'hBFFF);
    // R5 fixed top
    read_rom("R5 fixed C000", 32'hC000);
    read_rom("R5 fixed FFFF", 32'hFFFF);
    // R6 mask on 16-bank instance
    do_write(32'h8000, 32'h1F);
    read_rom("R6 mask", 32'h9ABC);
    // R7 $FF to mirroring page
    do_write(32'h9000, 32'hFF);
    read_rom("R7 FF no side effect", 32'h8000);
    read_all("R7 after FF");
    // R11 sub-addresses $x001 and $x002 in both wirings
    do_write(32'h8001, 32'h03);
    read_rom("R11 sub1", 32'h8010);
    do_write(32'hA002, 32'h15);
    read_rom("R11 sub2", 32'hA010);
    // R10 writes elsewhere ignored
    do_write(32'hC000, 32'h1F);
    do_write(32'h7000, 32'h01);
    do_write(32'hB003, 32'h0F);
    do_write(32'h5FFF, 32'hFF);
    read_rom("R10 ignored $8000", 32'h8000);
    read_rom("R10 ignored $A000", 32'hA000);
    read_all("R10 ignored");
    // R8 latch set
    do_write(32'h6ABC, 32'h01);
    read_all("R8 latch set");

    for (int i = 0; i < 300; i++) begin
      do_write(pick_addr(), int'($urandom_range(0, 255)));
      read_all("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule